// File: doc/BRIEF.md
# RF Front-End Slave Register Bank

This block is the register file of a serial front-end control slave that steers a two-mode power amplifier. A frame decoder in front of it has already turned the serial traffic into a parallel register access: a 5-bit register address, write data with a write strobe, a read strobe with combinational read data, and a flag that marks a write as broadcast or group-addressed. The decoder also sends one-cycle pulses for each framing error that it detects. The bank turns the stored state into two amplifier controls: an enable and a 2-bit bias mode.

Registers 0x00 and 0x01 are trigger-capable. A write to one of them lands in a shadow copy and only reaches the live copy when trigger 0 fires, unless trigger 0 is masked. When it is masked, writes go straight through. Register 0x1C holds the power state, three trigger masks and three self-clearing trigger bits. Register 0x1A gathers sticky error flags and clears itself on read. Registers 0x1B and 0x1F hold the group and unique slave identifiers. Registers 0x1D and 0x1E return fixed identity bytes. Writing 1 to bit 7 of register 0x1A restores every default except the two slave identifiers.

Top module: `rffe_regbank`

## Requirements
- R1: After rst_n is released, reads return 0x00 at 0x00, 0x01, 0x1A and 0x1B, 0x80 at 0x1C and 0x1F at 0x1F. pa_en is 0 and pa_mode is 00.
- R2: Register 0x00 has 7 bits. Bit 7 always reads 0. pa_mode equals live bits 1:0 (01 is high-power, 10 is low-power). pa_en equals live bit 2, gated as stated in R10.
- R3: When mask bit 3 of 0x1C is 0, a write to 0x00 or 0x01 changes only the shadow copy, and reads return the live copy. A write to 0x1C with bit 0 set and bit 3 clear copies both shadows into the live registers. The copy is visible in the cycle after that write.
- R4: When mask bit 3 of 0x1C is 1, a write to 0x00 or 0x01 reaches the live copy, and the outputs follow in the cycle after the write.
- R5: Register 0x1C reads as {power[7:6], masks[5:3], 3'b000}. The trigger bits 2:0 always read 0.
- R6: The status bits are sticky: bit 6 command parity, bit 5 command length, bit 4 address parity, bit 3 data parity, bit 2 read of an unused address, bit 1 write to an unused address, bit 0 ID error. Each is set by its pulse or by the matching access.
- R7: A read of 0x1A returns the value held before the read, and the register is zero from the next cycle on. A flag whose pulse arrives in the same cycle as that read is kept.
- R8: Addresses 0x02 to 0x19 read 0x00, and writes to them change no register.
- R9: A broadcast write to 0x1C updates bits 7:6 and fires triggers, and leaves the masks unchanged. A broadcast write to any other address changes nothing.
- R10: pa_en is 0 whenever the power field of 0x1C is not 00 (01 startup, 10 low power, 11 reserved).
- R11: A unicast write to 0x1A with bit 7 set restores the reset values of 0x00, 0x01, 0x1A and 0x1C, including the shadows. The slave identifiers in 0x1B and 0x1F keep their values.
- R12: 0x1D reads 0x0A and 0x1E reads 0x07, and writes to them are ignored. Bits 5:4 of 0x1F read 01.
- R13: Bits 3:0 of 0x1B and bits 3:0 of 0x1F are writable by unicast writes. Bits 7:4 of 0x1B read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 5 | Register address of the current access |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| bcast_wr | input | 1 | Marks the current write as broadcast or group-addressed |
| err_cmd_par | input | 1 | Command frame parity error pulse |
| err_cmd_len | input | 1 | Command length error pulse |
| err_addr_par | input | 1 | Address frame parity error pulse |
| err_data_par | input | 1 | Data frame parity error pulse |
| err_id | input | 1 | Broadcast/group ID error pulse |
| rd_data | output | 8 | Read data, valid in the rd_en cycle, 0 otherwise |
| pa_en | output | 1 | Amplifier enable |
| pa_mode | output | 2 | Amplifier bias mode |

## Verification
Read data is combinational, so the bench compares rd_data with the model 1 ns after it drives the read strobe at the falling edge, in the same cycle. Every write, trigger, soft reset and status clear takes effect at the next rising edge. The model applies the access just after that edge, and the bench compares pa_en and pa_mode with the model at every falling edge. Status clearing is checked by a second read one access later, and the broadcast mask hold is checked by reading 0x1C after the broadcast write.

// File: rtl/rffe_pkg.sv
// Shared constants and types of the front-end slave register bank.
// Assumes a 5-bit register address space and 8-bit registers.
package rffe_pkg;
    localparam int RFFE_AW = 5;
    localparam int RFFE_DW = 8;

    localparam logic [RFFE_AW-1:0] A_UNUSED_LO = 5'h02;
    localparam logic [RFFE_AW-1:0] A_UNUSED_HI = 5'h19;
    localparam logic [RFFE_AW-1:0] A_STATUS    = 5'h1A;
    localparam logic [RFFE_AW-1:0] A_GROUP_ID  = 5'h1B;
    localparam logic [RFFE_AW-1:0] A_PWR_TRIG  = 5'h1C;
    localparam logic [RFFE_AW-1:0] A_PROD_ID   = 5'h1D;
    localparam logic [RFFE_AW-1:0] A_MFR_LO    = 5'h1E;
    localparam logic [RFFE_AW-1:0] A_UNIQUE_ID = 5'h1F;

    // Power state of the slave, field bits 7:6 of the power/trigger register
    typedef enum logic [1:0] {
        PWR_ACTIVE  = 2'b00,
        PWR_STARTUP = 2'b01,
        PWR_LOW     = 2'b10,
        PWR_RSVD    = 2'b11
    } pwr_state_t;

    // Status flag positions
    localparam int ST_SOFT_RST = 7;
    localparam int ST_CMD_PAR  = 6;
    localparam int ST_CMD_LEN  = 5;
    localparam int ST_ADDR_PAR = 4;
    localparam int ST_DATA_PAR = 3;
    localparam int ST_RD_UNUSED = 2;
    localparam int ST_WR_UNUSED = 1;
    localparam int ST_ID_ERR   = 0;
endpackage

// File: rtl/rffe_shadow_bank.sv
// Shadow/live register pairs for the trigger-capable registers.
// Each write lands in the shadow copy. It also reaches the live copy when
// the direct path is open (trigger masked). A fire pulse copies every
// shadow into its live copy. Bits cleared in BIT_MASK are not stored.
// Assumes wr_sel is one-hot or zero and never coincides with fire.
module rffe_shadow_bank #(
    parameter int NUM_REGS = 2,
    parameter int DW = 8,
    parameter logic [NUM_REGS*DW-1:0] BIT_MASK = 16'hFF7F
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   soft_rst,
    input  logic [NUM_REGS-1:0]    wr_sel,
    input  logic                   direct,
    input  logic                   fire,
    input  logic [DW-1:0]          wr_data,
    output logic [NUM_REGS*DW-1:0] live_flat
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_pair
        localparam logic [DW-1:0] KEEP = BIT_MASK[i*DW +: DW];
        logic [DW-1:0] shadow_q;
        logic [DW-1:0] live_q;

        // Shadow copy: captures every addressed write
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) begin
                shadow_q <= '0;
            end else if (wr_sel[i]) begin
                shadow_q <= wr_data & KEEP;
            end
        end

        // Live copy: direct write when masked, else loaded on fire
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) begin
                live_q <= '0;
            end else if (wr_sel[i] && direct) begin
                live_q <= wr_data & KEEP;
            end else if (fire) begin
                live_q <= shadow_q;
            end
        end

        assign live_flat[i*DW +: DW] = live_q;
    end
endmodule

// File: rtl/rffe_status_reg.sv
// Sticky clear-on-read error status.
// Flags are ORed in from one-cycle set pulses. A read strobe clears the
// register at the following edge, but pulses of that same cycle survive.
// A soft reset empties it outright.
module rffe_status_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          rd_clear,
    input  logic [DW-1:0] set_vec,
    output logic [DW-1:0] status
);
    logic [DW-1:0] status_q;

    // Accumulate flags, clear on read completion
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            status_q <= '0;
        end else begin
            status_q <= (rd_clear ? '0 : status_q) | set_vec;
        end
    end

    assign status = status_q;
endmodule

// File: rtl/rffe_ctrl_regs.sv
// Power state, trigger masks and slave identifiers.
// Unicast writes reach every field of their register. Broadcast writes to
// the power/trigger register touch only the power field. Soft reset
// restores power state and masks, and leaves both identifiers alone.
module rffe_ctrl_regs
    import rffe_pkg::*;
#(
    parameter int NUM_TRIG = 3,
    parameter int ID_W = 4,
    parameter logic [ID_W-1:0] UNIQUE_RST = 4'hF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                soft_rst,
    input  logic                wr_pwr,
    input  logic                wr_pwr_uc,
    input  logic                wr_gid,
    input  logic                wr_uid,
    input  logic [RFFE_DW-1:0]  wr_data,
    output pwr_state_t          pwr_state,
    output logic [NUM_TRIG-1:0] trig_mask,
    output logic [ID_W-1:0]     group_id,
    output logic [ID_W-1:0]     unique_id
);
    pwr_state_t          pwr_q;
    logic [NUM_TRIG-1:0] mask_q;
    logic [ID_W-1:0]     gid_q;
    logic [ID_W-1:0]     uid_q;

    // Power field: any write to the power/trigger register
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            pwr_q <= PWR_LOW;
        end else if (wr_pwr) begin
            pwr_q <= pwr_state_t'(wr_data[RFFE_DW-1 -: 2]);
        end
    end

    // Mask field: unicast writes only
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            mask_q <= '0;
        end else if (wr_pwr_uc) begin
            mask_q <= wr_data[NUM_TRIG +: NUM_TRIG];
        end
    end

    // Identifiers: hardware reset only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gid_q <= '0;
            uid_q <= UNIQUE_RST;
        end else begin
            if (wr_gid) gid_q <= wr_data[ID_W-1:0];
            if (wr_uid) uid_q <= wr_data[ID_W-1:0];
        end
    end

    assign pwr_state = pwr_q;
    assign trig_mask = mask_q;
    assign group_id  = gid_q;
    assign unique_id = uid_q;
endmodule

// File: rtl/rffe_regbank.sv
// Top of the front-end slave register bank.
// Decodes the parallel register access port, routes writes to the shadow
// bank, control registers and status register, builds read data and
// drives the amplifier controls. Assumes wr_en and rd_en are never high
// together and that each strobe lasts one cycle per access.
module rffe_regbank
    import rffe_pkg::*;
#(
    parameter int NUM_TRIG_REGS = 2,
    parameter int NUM_TRIG = 3,
    parameter logic [7:0] PROD_ID = 8'h0A,
    parameter logic [7:0] MFR_LO = 8'h07,
    parameter logic [1:0] MFR_HI = 2'b01,
    parameter logic [3:0] UNIQUE_RST = 4'hF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] reg_addr,
    input  logic [7:0] wr_data,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic       bcast_wr,
    input  logic       err_cmd_par,
    input  logic       err_cmd_len,
    input  logic       err_addr_par,
    input  logic       err_data_par,
    input  logic       err_id,
    output logic [7:0] rd_data,
    output logic       pa_en,
    output logic [1:0] pa_mode
);
    localparam int ID_W = 4;
    localparam int LIVE_W = NUM_TRIG_REGS * RFFE_DW;

    logic                     wr_uc;
    logic                     unused_hit;
    logic                     wr_pwr;
    logic                     new_mask0;
    logic                     fire0;
    logic                     soft_rst;
    logic [NUM_TRIG_REGS-1:0] wr_sel;
    logic [LIVE_W-1:0]        live_flat;
    logic [RFFE_DW-1:0]       set_vec;
    logic [RFFE_DW-1:0]       status;
    pwr_state_t               pwr_state;
    logic [NUM_TRIG-1:0]      trig_mask;
    logic [ID_W-1:0]          group_id;
    logic [ID_W-1:0]          unique_id;
    logic [RFFE_DW-1:0]       amp_reg;

    // Access decode shared by all register groups
    always_comb begin
        wr_uc      = wr_en && !bcast_wr;
        unused_hit = (reg_addr >= A_UNUSED_LO) && (reg_addr <= A_UNUSED_HI);
        wr_pwr     = wr_en && (reg_addr == A_PWR_TRIG);
        new_mask0  = bcast_wr ? trig_mask[0] : wr_data[NUM_TRIG];
        fire0      = wr_pwr && wr_data[0] && !new_mask0;
        soft_rst   = wr_uc && (reg_addr == A_STATUS) && wr_data[ST_SOFT_RST];
    end

    // One select line per trigger-capable register
    for (genvar i = 0; i < NUM_TRIG_REGS; i++) begin : g_sel
        assign wr_sel[i] = wr_uc && (reg_addr == 5'(i));
    end

    rffe_shadow_bank #(
        .NUM_REGS (NUM_TRIG_REGS),
        .DW       (RFFE_DW),
        .BIT_MASK ({{(NUM_TRIG_REGS-1){8'hFF}}, 8'h7F})
    ) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .wr_sel    (wr_sel),
        .direct    (trig_mask[0]),
        .fire      (fire0),
        .wr_data   (wr_data),
        .live_flat (live_flat)
    );

    // Error set vector: decoder pulses plus unused-address accesses
    always_comb begin
        set_vec               = '0;
        set_vec[ST_CMD_PAR]   = err_cmd_par;
        set_vec[ST_CMD_LEN]   = err_cmd_len;
        set_vec[ST_ADDR_PAR]  = err_addr_par;
        set_vec[ST_DATA_PAR]  = err_data_par;
        set_vec[ST_RD_UNUSED] = rd_en && unused_hit;
        set_vec[ST_WR_UNUSED] = wr_en && unused_hit;
        set_vec[ST_ID_ERR]    = err_id;
    end

    rffe_status_reg #(
        .DW (RFFE_DW)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .rd_clear (rd_en && (reg_addr == A_STATUS)),
        .set_vec  (set_vec),
        .status   (status)
    );

    rffe_ctrl_regs #(
        .NUM_TRIG   (NUM_TRIG),
        .ID_W       (ID_W),
        .UNIQUE_RST (UNIQUE_RST)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .wr_pwr    (wr_pwr),
        .wr_pwr_uc (wr_pwr && !bcast_wr),
        .wr_gid    (wr_uc && (reg_addr == A_GROUP_ID)),
        .wr_uid    (wr_uc && (reg_addr == A_UNIQUE_ID)),
        .wr_data   (wr_data),
        .pwr_state (pwr_state),
        .trig_mask (trig_mask),
        .group_id  (group_id),
        .unique_id (unique_id)
    );

    // Read data multiplexer, zero outside a read strobe
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (reg_addr < 5'(NUM_TRIG_REGS)) begin
                rd_data = live_flat[reg_addr*RFFE_DW +: RFFE_DW];
            end else begin
                case (reg_addr)
                    A_STATUS:    rd_data = status;
                    A_GROUP_ID:  rd_data = {4'h0, group_id};
                    A_PWR_TRIG:  rd_data = {pwr_state, trig_mask, 3'b000};
                    A_PROD_ID:   rd_data = PROD_ID;
                    A_MFR_LO:    rd_data = MFR_LO;
                    A_UNIQUE_ID: rd_data = {2'b00, MFR_HI, unique_id};
                    default:     rd_data = '0;
                endcase
            end
        end
    end

    // Amplifier controls from the live copy of register 0
    always_comb begin
        amp_reg = live_flat[RFFE_DW-1:0];
        pa_mode = amp_reg[1:0];
        pa_en   = amp_reg[2] && (pwr_state == PWR_ACTIVE);
    end
endmodule

// File: rtl/rffe_regbank_chk.sv
// Property checker for rffe_regbank, attached by bind.
// Observes ports and a few internal registers of the top.
module rffe_regbank_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] reg_addr,
    input logic       wr_en,
    input logic       rd_en,
    input logic       bcast_wr,
    input logic [7:0] wr_data,
    input logic [4:0] errs,
    input logic [7:0] rd_data,
    input logic       pa_en,
    input logic [1:0] pwr_state,
    input logic [2:0] trig_mask,
    input logic [7:0] status,
    input logic [3:0] group_id,
    input logic [3:0] unique_id
);
    // R10
    pa_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pa_en |-> (pwr_state == 2'b00));

    // R7
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && reg_addr == 5'h1A && errs == 5'b0) |=> (status == 8'h00));

    // R9
    bcast_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bcast_wr && reg_addr == 5'h1C) |=> $stable(trig_mask));

    // R5
    trig_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_addr == 5'h1C) |-> (rd_data[2:0] == 3'b000));

    // R8
    unused_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_addr >= 5'h02 && reg_addr <= 5'h19) |-> (rd_data == 8'h00));

    // R11
    soft_rst_ids_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !bcast_wr && reg_addr == 5'h1A && wr_data[7]) |=> ($stable(group_id) && $stable(unique_id)));

    // R12
    prod_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_addr == 5'h1D) |-> (rd_data == 8'h0A));
endmodule

bind rffe_regbank rffe_regbank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .bcast_wr  (bcast_wr),
    .wr_data   (wr_data),
    .errs      ({err_cmd_par, err_cmd_len, err_addr_par, err_data_par, err_id}),
    .rd_data   (rd_data),
    .pa_en     (pa_en),
    .pwr_state (pwr_state),
    .trig_mask (trig_mask),
    .status    (status),
    .group_id  (group_id),
    .unique_id (unique_id)
);

// File: tb/tb_rffe_regbank.sv
`timescale 1ns/1ps
// Bench for rffe_regbank: behavioural model updated per access, outputs
// compared every falling edge, read data compared in the read cycle.
module tb_rffe_regbank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] wr_data = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       bcast_wr = 1'b0;
    logic       err_cmd_par = 1'b0;
    logic       err_cmd_len = 1'b0;
    logic       err_addr_par = 1'b0;
    logic       err_data_par = 1'b0;
    logic       err_id = 1'b0;
    logic [7:0] rd_data;
    logic       pa_en;
    logic [1:0] pa_mode;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit live = 0;

    // Model state
    int m_live[2];
    int m_shad[2];
    int m_pwr;
    int m_mask;
    int m_stat;
    int m_gid;
    int m_uid;

    always #2.5 clk = ~clk;

    rffe_regbank dut (
        .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .wr_data (wr_data),
        .wr_en (wr_en), .rd_en (rd_en), .bcast_wr (bcast_wr),
        .err_cmd_par (err_cmd_par), .err_cmd_len (err_cmd_len),
        .err_addr_par (err_addr_par), .err_data_par (err_data_par),
        .err_id (err_id), .rd_data (rd_data), .pa_en (pa_en), .pa_mode (pa_mode)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic model_defaults(input bit keep_ids);
        m_live = '{0, 0};
        m_shad = '{0, 0};
        m_pwr = 2;
        m_mask = 0;
        m_stat = 0;
        if (!keep_ids) begin
            m_gid = 0;
            m_uid = 15;
        end
    endtask

    function automatic int model_read(input int a);
        if (a < 2) return m_live[a];
        if (a == 26) return m_stat;
        if (a == 27) return m_gid;
        if (a == 28) return m_pwr * 64 + m_mask * 8;
        if (a == 29) return 10;
        if (a == 30) return 7;
        if (a == 31) return 16 + m_uid;
        return 0;
    endfunction

    task automatic model_write(input int a, input int d, input bit bc);
        bit fire;
        fire = 0;
        if (a >= 2 && a <= 25) begin
            m_stat = m_stat | 2;
        end else if (bc) begin
            if (a == 28) begin
                m_pwr = d / 64;
                fire = (d % 2 == 1) && (m_mask % 2 == 0);
            end
        end else if (a < 2) begin
            m_shad[a] = (a == 0) ? d % 128 : d;
            if (m_mask % 2 == 1) m_live[a] = m_shad[a];
        end else if (a == 26) begin
            if (d >= 128) model_defaults(1);
        end else if (a == 27) begin
            m_gid = d % 16;
        end else if (a == 28) begin
            m_pwr = d / 64;
            m_mask = (d / 8) % 8;
            fire = (d % 2 == 1) && (m_mask % 2 == 0);
        end else if (a == 31) begin
            m_uid = d % 16;
        end
        if (fire) begin
            m_live[0] = m_shad[0];
            m_live[1] = m_shad[1];
        end
    endtask

    // One access: e = {cmd_par, cmd_len, addr_par, data_par, id}
    task automatic access(input bit is_wr, input int a, input int d, input bit bc,
                          input logic [4:0] e, input string req);
        @(negedge clk);
        reg_addr = 5'(a);
        wr_data = 8'(d);
        wr_en = is_wr;
        rd_en = !is_wr;
        bcast_wr = bc;
        {err_cmd_par, err_cmd_len, err_addr_par, err_data_par, err_id} = e;
        #1;
        if (!is_wr) check(req, rd_data, model_read(a));
        @(posedge clk);
        #1;
        wr_en = 0; rd_en = 0; bcast_wr = 0;
        {err_cmd_par, err_cmd_len, err_addr_par, err_data_par, err_id} = '0;
        if (is_wr) begin
            model_write(a, d, bc);
        end else begin
            if (a == 26) m_stat = 0;
            if (a >= 2 && a <= 25) m_stat = m_stat | 4;
        end
        m_stat = m_stat | (e[4] ? 64 : 0) | (e[3] ? 32 : 0) | (e[2] ? 16 : 0)
                        | (e[1] ? 8 : 0) | (e[0] ? 1 : 0);
    endtask

    task automatic wr(input int a, input int d, input string req);
        access(1, a, d, 0, 5'b0, req);
    endtask

    task automatic rd(input int a, input string req);
        access(0, a, 0, 0, 5'b0, req);
    endtask

    // Every-clock comparison of the amplifier controls (R2, R10)
    always @(negedge clk) begin
        if (live) begin
            check("R2 pa_mode", pa_mode, m_live[0] % 4);
            check("R10 pa_en", pa_en, ((m_live[0] / 4) % 2 == 1) && (m_pwr == 0));
        end
    end

    initial begin
        model_defaults(0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        live = 1;
        // R1 reset values
        rd(0, "R1 reg0"); rd(1, "R1 reg1"); rd(26, "R1 status");
        rd(27, "R1 group"); rd(28, "R1 pwr/trig"); rd(31, "R1 unique");
        // R3 shadow write, then trigger
        wr(0, 8'hFD, "R3");
        wr(1, 8'h5A, "R3");
        rd(0, "R3 live unchanged"); rd(1, "R3 live unchanged");
        wr(28, 8'h01, "R3 fire");
        rd(0, "R2 R3 live after fire, bit7 zero"); rd(1, "R3 reg1 after fire");
        // R4 masked: direct write
        wr(28, 8'h08, "R4 mask");
        wr(0, 8'h06, "R4 direct");
        rd(0, "R4 live"); rd(28, "R5 trig bits read 0");
        wr(28, 8'h0F, "R5 trig with mask");
        rd(28, "R5 read");
        // R9 broadcast
        access(1, 28, 8'h40, 1, 5'b0, "R9 bcast pwr");
        rd(28, "R9 mask kept"); rd(0, "R10 pa off in startup");
        access(1, 0, 8'h01, 1, 5'b0, "R9 bcast other");
        rd(0, "R9 bcast ignored");
        wr(28, 8'h28, "R9 mask 101");
        access(1, 28, 8'h01, 1, 5'b0, "R9 bcast fire");
        rd(28, "R9 mask kept 101");
        // R10 reserved and low power
        wr(28, 8'hC8, "R10 reserved"); rd(28, "R10");
        wr(28, 8'h88, "R10 low"); wr(28, 8'h08, "R10 active");
        // R6 R7 status
        access(0, 29, 0, 0, 5'b10010, "R6 pulses");
        rd(26, "R6 status flags"); rd(26, "R7 cleared");
        rd(5, "R8 unused read"); rd(26, "R6 R8 rd unused flag");
        wr(16, 8'hFF, "R8 unused write"); rd(0, "R8 no effect");
        rd(26, "R6 wr unused flag");
        access(0, 26, 0, 0, 5'b00101, "R6 status");
        rd(26, "R7 same-cycle pulse kept"); rd(26, "R7 cleared");
        access(0, 30, 0, 0, 5'b01000, "R12 mfr lo"); rd(26, "R6 len");
        // R12 R13 identifiers
        wr(29, 8'h55, "R12"); rd(29, "R12 prod id"); rd(30, "R12 mfr");
        wr(27, 8'hFA, "R13"); rd(27, "R13 group");
        wr(31, 8'h23, "R13"); rd(31, "R12 R13 unique");
        // R11 soft reset
        wr(1, 8'h77, "R11 prep"); access(1, 9, 0, 0, 5'b10000, "R11 prep");
        wr(26, 8'h80, "R11 soft reset");
        rd(0, "R11 reg0"); rd(1, "R11 reg1"); rd(28, "R11 pwr");
        rd(26, "R11 status"); rd(27, "R11 group kept"); rd(31, "R11 unique kept");
        wr(28, 8'h01, "R11 shadow cleared"); rd(1, "R11 shadow reg1");
        repeat (2) @(negedge clk);
        live = 0;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule